// File: doc/BRIEF.md
# Event Timestamp Capture Controller

This block builds one time word for each event on four timing channels. A shared timebase keeps two counts: a 4-bit phase count, which advances on every 1 ns tick strobe and tells which tick inside the current 16-tick system period is active, and a 5-bit coarse count of whole system periods since the last sync marker. Each channel receives a stretched interval pulse whose width is proportional to a picosecond-scale interval. The pulse is brought into the fast counting clock domain and its high time is measured in fast-clock cycles.

When a channel's pulse rises, the timebase fields are captured and an event flag is raised for one cycle. When the pulse falls, the captured fields and the measured width form a 20-bit word, which is written into that channel's own four-entry queue. A reader selects a channel and raises a request. The oldest word of that queue then appears one cycle later with a valid flag.

Top module: `etc_top`

## Requirements
- R1: The phase count advances by one on each cycle where `tick_i` is high, wrapping from 15 to 0. The coarse count advances by one on each cycle where the phase wraps.
- R2: A cycle with `sync_i` high sets both the phase and coarse counts to 0 on the next edge. This takes priority over a tick in the same cycle.
- R3: The coarse count is 5 bits wide and wraps from 31 to 0.
- R4: Each pulse input passes through two flops. `event_o[c]` is high for exactly one cycle: the first cycle in which the synchronised pulse of channel c is high.
- R5: In that event cycle, the current coarse and phase values are captured for the channel.
- R6: When the synchronised pulse falls, the channel stores a word with coarse in bits 19:15, phase in bits 14:11 and, in bits 10:0, the number of cycles the synchronised pulse was high.
- R7: The width field saturates at 2047 and does not wrap. A word whose width reached saturation is read with `rd_ovf_o` high. `rd_ovf_o` is low for every other word.
- R8: Each channel holds up to 4 words in arrival order. A request on channel `rd_sel_i` with a non-empty queue pops the oldest word and presents it on `rd_data_o` with `rd_valid_o` high in the next cycle. A request on an empty queue gives `rd_valid_o` low and changes nothing.
- R9: A word arriving at a full queue is discarded. The channel's 8-bit drop count in `drop_cnt_o[8c+7:8c]` then increments, saturating at 255.
- R10: If a word arrives at a full queue in the same cycle that the queue is popped, the word is accepted and no drop is counted.
- R11: After reset, all queues are empty, `rd_valid_o`, `event_o` and every drop count are 0, and the coarse and phase counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Periodic sync marker, restarts the timebase |
| tick_i | input | 1 | 1 ns tick strobe |
| pulse_i | input | 4 | Stretched interval pulse per channel (asynchronous) |
| rd_req_i | input | 1 | Read request |
| rd_sel_i | input | 2 | Channel selected for the read |
| rd_valid_o | output | 1 | Read word is valid |
| rd_data_o | output | 20 | Read word {coarse, phase, width} |
| rd_ovf_o | output | 1 | Width of the read word saturated |
| event_o | output | 4 | One-cycle event flag per channel |
| drop_cnt_o | output | 32 | Four 8-bit drop counters |

## Verification
The two functions that can coincide are the storing of a finished word and a pop of that same channel's queue. The bench fills a queue to four entries, then lowers that channel's pulse and places the read request on the exact edge where the falling edge reaches the write stage. The reference model pops first and then accepts the arriving word. Every following read and the unchanged drop count show whether the arriving word was kept. A second collision, sync arriving together with a tick, is provoked on purpose. It is judged through the timebase fields captured by the next event.

// File: rtl/etc_pkg.sv
package etc_pkg;
    parameter int CH_N     = 4;
    parameter int COARSE_W = 5;
    parameter int PHASE_W  = 4;
    parameter int WIDTH_W  = 11;
    parameter int FIFO_D   = 4;
    parameter int DROP_W   = 8;
    localparam int WORD_W  = COARSE_W + PHASE_W + WIDTH_W;
    localparam int SEL_W   = $clog2(CH_N);

    typedef struct packed {
        logic                ovf;
        logic [COARSE_W-1:0] coarse;
        logic [PHASE_W-1:0]  phase;
        logic [WIDTH_W-1:0]  width;
    } evt_word_t;
endpackage

// File: rtl/etc_timebase.sv
module etc_timebase
    import etc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_i,
    input  logic                tick_i,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [PHASE_W-1:0]  phase_o
);
    localparam logic [PHASE_W-1:0] PHASE_LAST = '1;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [PHASE_W-1:0]  phase;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d.coarse = '0;
            st_d.phase  = '0;
        end else if (tick_i) begin
            st_d.phase = st_q.phase + 1'b1;
            if (st_q.phase == PHASE_LAST) begin
                st_d.coarse = st_q.coarse + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coarse_o = st_q.coarse;
    assign phase_o  = st_q.phase;
endmodule

// File: rtl/etc_chan.sv
module etc_chan
    import etc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pulse_i,
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic [PHASE_W-1:0]  phase_i,
    output logic                event_o,
    output logic                wr_o,
    output evt_word_t           word_o
);
    localparam logic [WIDTH_W-1:0] WIDTH_MAX = '1;

    typedef struct packed {
        logic [2:0]          sh;
        logic [WIDTH_W-1:0]  cnt;
        logic                ovf;
        logic [COARSE_W-1:0] cap_c;
        logic [PHASE_W-1:0]  cap_p;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   rise, fall;

    assign rise = st_q.sh[1] & ~st_q.sh[2];
    assign fall = ~st_q.sh[1] & st_q.sh[2];

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[1:0], pulse_i};
        if (rise) begin
            st_d.cap_c = coarse_i;
            st_d.cap_p = phase_i;
            st_d.cnt   = WIDTH_W'(1);
            st_d.ovf   = 1'b0;
        end else if (st_q.sh[1]) begin
            if (st_q.cnt == WIDTH_MAX) st_d.ovf = 1'b1;
            else                       st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign event_o       = rise;
    assign wr_o          = fall;
    assign word_o.ovf    = st_q.ovf;
    assign word_o.coarse = st_q.cap_c;
    assign word_o.phase  = st_q.cap_p;
    assign word_o.width  = st_q.cnt;
endmodule

// File: rtl/etc_fifo.sv
module etc_fifo
    import etc_pkg::*;
#(
    parameter int DEPTH = FIFO_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  evt_word_t         wdata_i,
    input  logic              rd_i,
    output logic              empty_o,
    output evt_word_t         rdata_o,
    output logic [DROP_W-1:0] drop_cnt_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DEPTH);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    typedef struct packed {
        evt_word_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      wr_ptr;
        logic [PTR_W-1:0]      rd_ptr;
        logic [CNT_W-1:0]      count;
        logic [DROP_W-1:0]     drops;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     pop, push;

    always_comb begin
        st_d = st_q;
        pop  = rd_i && (st_q.count != '0);
        push = wr_i && ((st_q.count != CNT_FULL) || pop);
        if (pop) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
        if (push) begin
            st_d.mem[st_q.wr_ptr] = wdata_i;
            st_d.wr_ptr           = st_q.wr_ptr + 1'b1;
        end
        st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
        if (wr_i && !push && (st_q.drops != DROP_MAX)) begin
            st_d.drops = st_q.drops + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty_o    = (st_q.count == '0);
    assign rdata_o    = st_q.mem[st_q.rd_ptr];
    assign drop_cnt_o = st_q.drops;
endmodule

// File: rtl/etc_top.sv
module etc_top
    import etc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_i,
    input  logic                   tick_i,
    input  logic [CH_N-1:0]        pulse_i,
    input  logic                   rd_req_i,
    input  logic [SEL_W-1:0]       rd_sel_i,
    output logic                   rd_valid_o,
    output logic [WORD_W-1:0]      rd_data_o,
    output logic                   rd_ovf_o,
    output logic [CH_N-1:0]        event_o,
    output logic [CH_N*DROP_W-1:0] drop_cnt_o
);
    typedef struct packed {
        logic      valid;
        evt_word_t word;
    } rd_st_t;

    logic [COARSE_W-1:0] tmr_coarse;
    logic [PHASE_W-1:0]  tmr_phase;
    logic [CH_N-1:0]     empty_w;
    logic [CH_N-1:0]     pop_w;
    evt_word_t           head_w [CH_N];
    rd_st_t              rd_d, rd_q;

    etc_timebase u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (sync_i),
        .tick_i   (tick_i),
        .coarse_o (tmr_coarse),
        .phase_o  (tmr_phase)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic      wr_w;
        evt_word_t word_w;

        assign pop_w[g] = rd_req_i && (rd_sel_i == SEL_W'(g));

        etc_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pulse_i  (pulse_i[g]),
            .coarse_i (tmr_coarse),
            .phase_i  (tmr_phase),
            .event_o  (event_o[g]),
            .wr_o     (wr_w),
            .word_o   (word_w)
        );

        etc_fifo u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (wr_w),
            .wdata_i    (word_w),
            .rd_i       (pop_w[g]),
            .empty_o    (empty_w[g]),
            .rdata_o    (head_w[g]),
            .drop_cnt_o (drop_cnt_o[g*DROP_W +: DROP_W])
        );
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_req_i && !empty_w[rd_sel_i];
        if (rd_d.valid) rd_d.word = head_w[rd_sel_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid_o = rd_q.valid;
    assign rd_ovf_o   = rd_q.word.ovf;
    assign rd_data_o  = {rd_q.word.coarse, rd_q.word.phase, rd_q.word.width};
endmodule

// File: rtl/etc_chk.sv
module etc_chk
    import etc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sync_i,
    input logic                   tick_i,
    input logic [CH_N-1:0]        event_o,
    input logic                   rd_req_i,
    input logic                   rd_valid_o,
    input logic [WORD_W-1:0]      rd_data_o,
    input logic                   rd_ovf_o,
    input logic [CH_N*DROP_W-1:0] drop_cnt_o,
    input logic [COARSE_W-1:0]    coarse,
    input logic [PHASE_W-1:0]     phase
);
    localparam logic [WIDTH_W-1:0] WSAT = '1;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !sync_i) |=> (phase == PHASE_W'($past(phase) + 1'b1))); // R1

    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (phase == '0 && coarse == '0)); // R2

    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_o) |=> ((event_o & $past(event_o)) == '0)); // R4

    AST_SAT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && rd_ovf_o) |-> (rd_data_o[WIDTH_W-1:0] == WSAT)); // R7

    AST_RD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_req_i)); // R8

    AST_DROP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cnt_o[DROP_W-1:0] >= $past(drop_cnt_o[DROP_W-1:0])); // R9
endmodule

bind etc_top etc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .tick_i     (tick_i),
    .event_o    (event_o),
    .rd_req_i   (rd_req_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .rd_ovf_o   (rd_ovf_o),
    .drop_cnt_o (drop_cnt_o),
    .coarse     (tmr_coarse),
    .phase      (tmr_phase)
);

// File: tb/tb_etc_top.sv
module tb_etc_top;
    localparam int CLK_P = 10;
    localparam int NCH   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [3:0]  pulse_i = '0;
    logic        rd_req_i = 1'b0;
    logic [1:0]  rd_sel_i = '0;
    logic        rd_valid_o;
    logic [19:0] rd_data_o;
    logic        rd_ovf_o;
    logic [3:0]  event_o;
    logic [31:0] drop_cnt_o;

    etc_top dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .tick_i(tick_i),
        .pulse_i(pulse_i), .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ovf_o(rd_ovf_o),
        .event_o(event_o), .drop_cnt_o(drop_cnt_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur = "R11";
    bit    tick_en = 0;
    int    tick_div = 1;

    // behavioural reference state
    int m_s1[NCH], m_s2[NCH], m_s3[NCH];
    int m_cnt[NCH], m_ovf[NCH], m_cc[NCH], m_cp[NCH], m_drop[NCH];
    int mq[NCH][$];
    int m_phase, m_coarse;
    int m_rv, m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0; m_cnt[c] = 0;
                m_ovf[c] = 0; m_cc[c] = 0; m_cp[c] = 0; m_drop[c] = 0;
                mq[c].delete();
            end
            m_phase = 0; m_coarse = 0; m_rv = 0; m_rd = 0;
        end else begin
            // read path: pop happens before a same-cycle arrival is judged
            if (rd_req_i && mq[rd_sel_i].size() > 0) begin
                m_rv = 1;
                m_rd = mq[rd_sel_i].pop_front();
            end else begin
                m_rv = 0;
            end
            for (int c = 0; c < NCH; c++) begin
                if (m_s2[c] == 0 && m_s3[c] == 1) begin
                    if (mq[c].size() < 4)
                        mq[c].push_back((m_ovf[c] << 20) | (m_cc[c] << 15) | (m_cp[c] << 11) | m_cnt[c]);
                    else if (m_drop[c] < 255)
                        m_drop[c]++;
                end
                if (m_s2[c] == 1 && m_s3[c] == 0) begin
                    m_cc[c] = m_coarse; m_cp[c] = m_phase; m_cnt[c] = 1; m_ovf[c] = 0;
                end else if (m_s2[c] == 1) begin
                    if (m_cnt[c] == 2047) m_ovf[c] = 1;
                    else m_cnt[c]++;
                end
                m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = int'(pulse_i[c]);
            end
            if (sync_i) begin
                m_phase = 0; m_coarse = 0;
            end else if (tick_i) begin
                if (m_phase == 15) begin
                    m_phase = 0; m_coarse = (m_coarse + 1) % 32;
                end else begin
                    m_phase++;
                end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                chk("R4", $sformatf("event_o[%0d]", c), int'(event_o[c]),
                    int'(m_s2[c] == 1 && m_s3[c] == 0));
                chk((cur == "R10") ? "R10" : "R9", $sformatf("drop[%0d]", c),
                    int'(drop_cnt_o[c*8 +: 8]), m_drop[c]);
            end
            chk("R8", "rd_valid_o", int'(rd_valid_o), m_rv);
            if (m_rv == 1) begin
                chk(cur, "rd_data_o", int'(rd_data_o), m_rd & 20'hFFFFF);
                chk("R7", "rd_ovf_o", int'(rd_ovf_o), (m_rd >> 20) & 1);
            end
        end
    end

    int tcnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            tcnt++;
            tick_i = tick_en && ((tcnt % tick_div) == 0);
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int c, int len, int gap);
        pulse_i[c] = 1'b1;
        wait_n(len);
        pulse_i[c] = 1'b0;
        wait_n(gap);
    endtask

    task automatic rd(int c);
        rd_req_i = 1'b1; rd_sel_i = 2'(c);
        wait_n(1);
        rd_req_i = 1'b0;
    endtask

    task automatic drain(int c, int n);
        for (int i = 0; i < n; i++) rd(c);
        wait_n(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_n(4);
        // R11: state straight after reset release
        rst_n = 1'b1;
        wait_n(1);
        chk("R11", "rd_valid_o", int'(rd_valid_o), 0);
        chk("R11", "event_o", int'(event_o), 0);
        chk("R11", "drop_cnt_o", int'(drop_cnt_o), 0);
        pulse(0, 3, 4);
        drain(0, 1);   // captured timebase must be zero (R11)

        // R1/R3: continuous ticks across a full coarse wrap, events on ch0
        cur = "R1"; tick_en = 1; tick_div = 1;
        for (int k = 0; k < 14; k++) begin
            wait_n(37 + k);
            pulse(0, 2 + k, 4);
            drain(0, 1);
        end
        cur = "R3";
        for (int k = 0; k < 6; k++) begin
            wait_n(90);
            pulse(0, 5, 4);
            drain(0, 1);
        end
        // sparse ticks
        cur = "R1"; tick_div = 3;
        for (int k = 0; k < 5; k++) begin
            wait_n(11);
            pulse(1, 4, 4);
        end
        drain(1, 5);

        // R2: sync together with a tick, then an event near it
        cur = "R2"; tick_div = 1;
        wait_n(20);
        sync_i = 1'b1; wait_n(1); sync_i = 1'b0;
        pulse(2, 6, 4);
        pulse_i[3] = 1'b1; sync_i = 1'b1; wait_n(1); sync_i = 1'b0;
        wait_n(7); pulse_i[3] = 1'b0; wait_n(4);
        drain(2, 1); drain(3, 1);

        // R5/R6: overlapping pulses of different widths on all channels
        cur = "R6";
        pulse_i = 4'b0001; wait_n(3);
        pulse_i = 4'b0011; wait_n(5);
        pulse_i = 4'b0111; wait_n(2);
        pulse_i = 4'b1110; wait_n(9);
        pulse_i = 4'b1000; wait_n(1);
        pulse_i = 4'b0000; wait_n(5);
        cur = "R5";
        for (int c = 0; c < NCH; c++) drain(c, 1);

        // R7: saturated width on ch1, then a normal width clears the flag
        cur = "R7";
        pulse(1, 2100, 4);
        pulse(1, 9, 4);
        drain(1, 2);

        // R8: reads of empty queues
        cur = "R8";
        drain(0, 2); drain(3, 1);

        // R9: overfill ch2 until the drop counter saturates
        cur = "R9";
        for (int k = 0; k < 262; k++) pulse(2, 2, 2);
        wait_n(4);
        drain(2, 5);

        // R10: arrival into a full queue on the same edge as a pop
        cur = "R10";
        for (int k = 0; k < 4; k++) pulse(3, 3 + k, 3);
        pulse_i[3] = 1'b1; wait_n(8);
        pulse_i[3] = 1'b0;
        wait_n(2);
        rd_req_i = 1'b1; rd_sel_i = 2'd3;
        wait_n(1);
        rd_req_i = 1'b0;
        wait_n(4);
        drain(3, 5);

        wait_n(5);
        finish_run();
    end
endmodule